// File: doc/BRIEF.md
# Configurable Two-Input Gate-Array Evaluator

The block holds a genome in registers that describes a rectangular grid of uncommitted logic cells, arranged in `COLS` columns of `ROWS` cells. Every cell has exactly one output and exactly two inputs. It carries a 4-bit function gene that picks one of sixteen two-input operations, and two selector genes that name the nets feeding its inputs. A separate gene for each primary output names the net that drives that output. The grid is evaluated combinationally, so the primary outputs follow the primary inputs directly.

A sweep mode scores a configuration. It applies every primary-input combination in turn and compares the outputs with a target truth table held in registers. Over the whole sweep it accumulates the number of output bits that differ. A result of zero means the configuration implements the target completely.

Two further signals let an external search engine rank candidate genomes:
- a flag that reports any selector gene that breaks the connectivity rules;
- a count of the cells whose outputs actually reach a primary output, used as a gate-count metric.

Top module: `gate_array_eval`

## Requirements
- R1: Function codes 0 to 9 compute, from cell inputs a and b: 0 gives 0, 1 gives 1, 2 gives a, 3 gives b, 4 gives !a, 5 gives !b, 6 gives a&b, 7 gives a&!b, 8 gives !a&b, 9 gives !a&!b.
- R2: Function codes 10 to 15 compute: 10 gives a|b, 11 gives a|!b, 12 gives !a|b, 13 gives !a|!b, 14 gives a^b, 15 gives !(a^b).
- R3: Net numbering works as follows.
  - Nets 0 to N_IN-1 are the primary inputs `x_in[0..N_IN-1]`.
  - Cell index i drives net N_IN+i.
  - A cell's column is i/ROWS and its row is i%ROWS.
  - `cell_in_a` drives the cell's input a and `cell_in_b` drives its input b.
- R4: `illegal_genome` is 1 exactly when at least one selector is out of bounds. For a cell in column c, a selector is legal when it names a primary input, or a cell in a column k with c-LEVEL_BACK <= k < c. Selectors on cells whose function ignores that input are checked as well. An output selector is legal when it is below N_IN+ROWS*COLS.
- R5: `y_out[o]` equals the value of the net chosen by output selector o for the current `x_in`. The change is combinational, with no clock delay. An illegal selector contributes 0.
- R6: A `start` pulse while idle sets `busy` on the next edge. The sweep then applies combinations 0 to 2^N_IN-1, one per clock. `done` is high for exactly one cycle, visible 2^N_IN clock edges after the edge that accepted `start`, and `busy` falls at the same time.
- R7: At `done`, `mismatch` holds the sum, over all combinations, of the number of differing bits between the evaluated outputs and the target entry written at address equal to that combination. The value is held until the next sweep ends.
- R8: A genome that implements the target exactly yields `mismatch` = 0.
- R9: `active_cells` counts the cells reachable backwards from any legal output selector. The search follows only legal selectors of inputs that the function uses:
  - codes 0 and 1 use no input;
  - codes 2 and 4 use only a;
  - codes 3 and 5 use only b;
  - all other codes use both.
- R10: After reset the genome is cleared. Every function gene is 0, every selector is 0, and every target entry is 0. As a result `y_out` replicates `x_in[0]`, and `busy`, `done`, `mismatch`, `illegal_genome` and `active_cells` are all 0.
- R11: A `start` pulse while `busy` is ignored. The running sweep ends on its original schedule with its own count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_we | input | 1 | Write the genes of one cell |
| cell_idx | input | CIW | Cell index to write |
| cell_func | input | 4 | Function gene |
| cell_in_a | input | SW | Selector for input a |
| cell_in_b | input | SW | Selector for input b |
| out_we | input | 1 | Write one output selector |
| out_idx | input | OIW | Output index |
| out_net | input | SW | Net driving that output |
| tgt_we | input | 1 | Write one target truth-table entry |
| tgt_addr | input | N_IN | Input combination being written |
| tgt_bits | input | N_OUT | Desired outputs for that combination |
| x_in | input | N_IN | Primary inputs for direct evaluation |
| y_out | output | N_OUT | Evaluated primary outputs |
| start | input | 1 | Begin a sweep |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| mismatch | output | CW | Hamming total from the last sweep |
| illegal_genome | output | 1 | A selector breaks the connectivity rules |
| active_cells | output | AW | Cells on a path to an output |

## Verification
The embedded properties assume the following:
- Genome and target registers stay unchanged while a sweep runs.
- `start` is only a one-cycle request.

The bench writes genes and targets only between sweeps. It raises `start` for single cycles and drives every input at the falling edge. Its one deliberate violation of the idle-only convention is a second `start` pulse in the middle of a sweep, used to exercise R11. The random genomes are drawn from the legal window, so the sweep scores and active counts are compared against a bench-side model on configurations that satisfy R4.

// File: rtl/gate_array_eval.sv
module gate_array_eval #(
  parameter int N_IN       = 3,
  parameter int N_OUT      = 2,
  parameter int ROWS       = 3,
  parameter int COLS       = 4,
  parameter int LEVEL_BACK = 2,
  localparam int N_CELLS = ROWS * COLS,
  localparam int N_NETS  = N_IN + N_CELLS,
  localparam int N_COMB  = 1 << N_IN,
  localparam int SW      = $clog2(N_NETS),
  localparam int CIW     = (N_CELLS > 1) ? $clog2(N_CELLS) : 1,
  localparam int OIW     = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int CW      = $clog2(N_OUT * N_COMB + 1),
  localparam int AW      = $clog2(N_CELLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_we,
  input  logic [CIW-1:0]   cell_idx,
  input  logic [3:0]       cell_func,
  input  logic [SW-1:0]    cell_in_a,
  input  logic [SW-1:0]    cell_in_b,
  input  logic             out_we,
  input  logic [OIW-1:0]   out_idx,
  input  logic [SW-1:0]    out_net,
  input  logic             tgt_we,
  input  logic [N_IN-1:0]  tgt_addr,
  input  logic [N_OUT-1:0] tgt_bits,
  input  logic [N_IN-1:0]  x_in,
  output logic [N_OUT-1:0] y_out,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [CW-1:0]    mismatch,
  output logic             illegal_genome,
  output logic [AW-1:0]    active_cells
);

  logic [3:0]       gene_f  [N_CELLS];
  logic [SW-1:0]    gene_a  [N_CELLS];
  logic [SW-1:0]    gene_b  [N_CELLS];
  logic [SW-1:0]    out_sel [N_OUT];
  logic [N_OUT-1:0] target  [N_COMB];

  logic [N_IN-1:0]  idx;
  logic [CW-1:0]    acc;
  logic [CW-1:0]    step_err;
  logic [N_OUT-1:0] sweep_y;
  logic [N_NETS-1:0] live;
  logic [AW-1:0]    act_cnt;
  logic             bad;

  function automatic logic cell_op(input logic [3:0] f, input logic a, input logic b);
    case (f)
      4'd0:  return 1'b0;
      4'd1:  return 1'b1;
      4'd2:  return a;
      4'd3:  return b;
      4'd4:  return !a;
      4'd5:  return !b;
      4'd6:  return a & b;
      4'd7:  return a & !b;
      4'd8:  return !a & b;
      4'd9:  return !a & !b;
      4'd10: return a | b;
      4'd11: return a | !b;
      4'd12: return !a | b;
      4'd13: return !a | !b;
      4'd14: return a ^ b;
      default: return !(a ^ b);
    endcase
  endfunction

  function automatic logic sel_ok(input logic [SW-1:0] s, input int col);
    int sc;
    if (int'(s) < N_IN) return 1'b1;
    if (int'(s) >= N_NETS) return 1'b0;
    sc = (int'(s) - N_IN) / ROWS;
    return (sc < col) && (sc + LEVEL_BACK >= col);
  endfunction

  function automatic logic uses_a(input logic [3:0] f);
    return !(f == 4'd0 || f == 4'd1 || f == 4'd3 || f == 4'd5);
  endfunction

  function automatic logic uses_b(input logic [3:0] f);
    return !(f == 4'd0 || f == 4'd1 || f == 4'd2 || f == 4'd4);
  endfunction

  function automatic logic [N_OUT-1:0] evaluate(input logic [N_IN-1:0] x);
    logic [N_NETS-1:0] n;
    logic a, b;
    logic [N_OUT-1:0] y;
    n = '0;
    n[N_IN-1:0] = x;
    for (int i = 0; i < N_CELLS; i++) begin
      a = sel_ok(gene_a[i], i / ROWS) ? n[gene_a[i]] : 1'b0;
      b = sel_ok(gene_b[i], i / ROWS) ? n[gene_b[i]] : 1'b0;
      n[N_IN+i] = cell_op(gene_f[i], a, b);
    end
    for (int o = 0; o < N_OUT; o++)
      y[o] = (int'(out_sel[o]) < N_NETS) ? n[out_sel[o]] : 1'b0;
    return y;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CELLS; i++) begin
        gene_f[i] <= '0;
        gene_a[i] <= '0;
        gene_b[i] <= '0;
      end
      for (int o = 0; o < N_OUT; o++) out_sel[o] <= '0;
      for (int c = 0; c < N_COMB; c++) target[c] <= '0;
    end else begin
      if (cell_we && int'(cell_idx) < N_CELLS) begin
        gene_f[cell_idx] <= cell_func;
        gene_a[cell_idx] <= cell_in_a;
        gene_b[cell_idx] <= cell_in_b;
      end
      if (out_we && int'(out_idx) < N_OUT) out_sel[out_idx] <= out_net;
      if (tgt_we) target[tgt_addr] <= tgt_bits;
    end
  end

  always_comb y_out = evaluate(x_in);
  always_comb sweep_y = evaluate(idx);
  assign step_err = CW'($countones(sweep_y ^ target[idx]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx <= '0;
      acc <= '0;
      mismatch <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          idx <= '0;
          acc <= '0;
        end
      end else if (&idx) begin
        busy <= 1'b0;
        done <= 1'b1;
        idx <= '0;
        mismatch <= acc + step_err;
      end else begin
        idx <= idx + 1'b1;
        acc <= acc + step_err;
      end
    end
  end

  always_comb begin
    bad = 1'b0;
    for (int i = 0; i < N_CELLS; i++)
      bad = bad | !sel_ok(gene_a[i], i / ROWS) | !sel_ok(gene_b[i], i / ROWS);
    for (int o = 0; o < N_OUT; o++)
      bad = bad | (int'(out_sel[o]) >= N_NETS);
  end
  assign illegal_genome = bad;

  always_comb begin
    live = '0;
    act_cnt = '0;
    for (int o = 0; o < N_OUT; o++)
      if (int'(out_sel[o]) < N_NETS) live[out_sel[o]] = 1'b1;
    for (int i = N_CELLS - 1; i >= 0; i--) begin
      if (live[N_IN+i]) begin
        act_cnt = act_cnt + 1'b1;
        if (uses_a(gene_f[i]) && sel_ok(gene_a[i], i / ROWS)) live[gene_a[i]] = 1'b1;
        if (uses_b(gene_f[i]) && sel_ok(gene_b[i], i / ROWS)) live[gene_b[i]] = 1'b1;
      end
    end
  end
  assign active_cells = act_cnt;

  a_r6_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(&idx)) |=> busy);
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mismatch) <= N_OUT * N_COMB);
  a_r7_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(mismatch) || done);
  a_r9_active_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(active_cells) <= N_CELLS);

endmodule

// File: tb/test_gate_array_eval.sv
`timescale 1ns/1ps
module test_gate_array_eval;
  localparam int NI = 3, NO = 2, RW = 3, CL = 4, LB = 2;
  localparam int NC = RW * CL, NN = NI + NC, NCOMB = 1 << NI;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cell_we = 0, out_we = 0, tgt_we = 0, start = 0;
  logic [3:0] cell_idx = 0, cell_func = 0, cell_in_a = 0, cell_in_b = 0, out_net = 0;
  logic [0:0] out_idx = 0;
  logic [NI-1:0] tgt_addr = 0, x_in = 0;
  logic [NO-1:0] tgt_bits = 0, y_out;
  logic busy, done, illegal_genome;
  logic [4:0] mismatch;
  logic [3:0] active_cells;

  gate_array_eval #(.N_IN(NI), .N_OUT(NO), .ROWS(RW), .COLS(CL), .LEVEL_BACK(LB)) i_gate_array_eval (
    .clk, .rst_n, .cell_we, .cell_idx, .cell_func, .cell_in_a, .cell_in_b,
    .out_we, .out_idx, .out_net, .tgt_we, .tgt_addr, .tgt_bits, .x_in, .y_out,
    .start, .busy, .done, .mismatch, .illegal_genome, .active_cells);

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, t0 = 0;
  int m_f[NC], m_a[NC], m_b[NC], m_o[NO];
  logic [NO-1:0] m_t[NCOMB];
  int exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic op(int f, logic a, logic b);
    case (f)
      0: return 0;   1: return 1;   2: return a;   3: return b;
      4: return !a;  5: return !b;  6: return a & b;   7: return a & !b;
      8: return !a & b;  9: return !a & !b;  10: return a | b;  11: return a | !b;
      12: return !a | b; 13: return !a | !b; 14: return a ^ b; default: return !(a ^ b);
    endcase
  endfunction

  function automatic logic legal(int s, int col);
    if (s < NI) return 1;
    if (s >= NN) return 0;
    return ((s - NI) / RW < col) && ((s - NI) / RW + LB >= col);
  endfunction

  function automatic logic [NO-1:0] m_eval(logic [NI-1:0] x);
    logic [NN-1:0] n;
    logic [NO-1:0] y;
    n = '0;
    n[NI-1:0] = x;
    for (int i = 0; i < NC; i++)
      n[NI+i] = op(m_f[i], legal(m_a[i], i / RW) ? n[m_a[i]] : 1'b0,
                           legal(m_b[i], i / RW) ? n[m_b[i]] : 1'b0);
    for (int o = 0; o < NO; o++) y[o] = (m_o[o] < NN) ? n[m_o[o]] : 1'b0;
    return y;
  endfunction

  function automatic int m_active();
    logic [NN-1:0] lv;
    int c;
    lv = '0;
    c = 0;
    for (int o = 0; o < NO; o++) if (m_o[o] < NN) lv[m_o[o]] = 1;
    for (int i = NC - 1; i >= 0; i--)
      if (lv[NI+i]) begin
        c++;
        if (!(m_f[i] inside {0, 1, 3, 5}) && legal(m_a[i], i / RW)) lv[m_a[i]] = 1;
        if (!(m_f[i] inside {0, 1, 2, 4}) && legal(m_b[i], i / RW)) lv[m_b[i]] = 1;
      end
    return c;
  endfunction

  function automatic int m_score();
    int s;
    s = 0;
    for (int c = 0; c < NCOMB; c++) s += $countones(m_eval(c[NI-1:0]) ^ m_t[c]);
    return s;
  endfunction

  task automatic wr_cell(int i, int f, int a, int b);
    @(negedge clk);
    cell_we = 1; cell_idx = 4'(i); cell_func = 4'(f); cell_in_a = 4'(a); cell_in_b = 4'(b);
    m_f[i] = f; m_a[i] = a; m_b[i] = b;
    @(negedge clk);
    cell_we = 0;
  endtask

  task automatic wr_out(int o, int s);
    @(negedge clk);
    out_we = 1; out_idx = 1'(o); out_net = 4'(s); m_o[o] = s;
    @(negedge clk);
    out_we = 0;
  endtask

  task automatic wr_tgt(int c, logic [NO-1:0] v);
    @(negedge clk);
    tgt_we = 1; tgt_addr = NI'(c); tgt_bits = v; m_t[c] = v;
    @(negedge clk);
    tgt_we = 0;
  endtask

  task automatic chk_y(string tag);
    for (int x = 0; x < NCOMB; x++) begin
      x_in = NI'(x);
      #0.2;
      check(tag, int'(y_out), int'(m_eval(NI'(x))));
    end
  endtask

  function automatic int pick(int col);
    int span, k;
    span = (col < LB) ? col : LB;
    k = int'($urandom % (NI + RW * span));
    if (k < NI) return k;
    return NI + (col - span) * RW + (k - NI);
  endfunction

  task automatic run_sweep(bit restart);
    exp_q.push_back(m_score());
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; t0 = cyc;
    check("R6 busy after start", int'(busy), 1);
    if (restart) begin
      repeat (3) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
    end
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    check("R6 no extra done", int'(done), 0);
    check("R6 idle after done", int'(busy), 0);
  endtask

  always @(negedge clk) if (rst_n && done) begin
    if (exp_q.size() == 0) check("R11 unexpected done", 1, 0);
    else begin
      check("R7 mismatch", int'(mismatch), exp_q.pop_front());
      check("R6 latency", cyc - t0, NCOMB);
    end
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin m_f[i] = 0; m_a[i] = 0; m_b[i] = 0; end
    for (int o = 0; o < NO; o++) m_o[o] = 0;
    for (int c = 0; c < NCOMB; c++) m_t[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    x_in = 3'd5; #0.2;
    check("R10 y after reset", int'(y_out), 3);
    x_in = 3'd6; #0.2;
    check("R10 y after reset", int'(y_out), 0);
    check("R10 busy", int'(busy), 0);
    check("R10 done", int'(done), 0);
    check("R10 mismatch", int'(mismatch), 0);
    check("R10 illegal", int'(illegal_genome), 0);
    check("R10 active", int'(active_cells), 0);

    wr_out(0, NI);
    for (int f = 0; f < 16; f++) begin
      wr_cell(0, f, 0, 1);
      for (int x = 0; x < 4; x++) begin
        x_in = NI'(x); #0.2;
        check(f < 10 ? "R1 function" : "R2 function", int'(y_out[0]), int'(op(f, x[0], x[1])));
      end
    end

    wr_cell(0, 4, 0, 0);
    wr_cell(4, 2, 3, 0);
    wr_out(1, 7);
    for (int x = 0; x < NCOMB; x++) begin
      x_in = NI'(x); #0.2;
      check("R3 numbering", int'(y_out[1]), int'(!x[0]));
    end
    check("R9 chain active", int'(active_cells), 2);

    check("R4 legal base", int'(illegal_genome), 0);
    wr_cell(6, 6, 3, 6);  check("R4 window ok", int'(illegal_genome), 0);
    wr_cell(6, 0, 9, 0);  check("R4 self column", int'(illegal_genome), 1);
    wr_cell(6, 0, 0, 10); check("R4 same column", int'(illegal_genome), 1);
    wr_cell(6, 0, 12, 0); check("R4 later column", int'(illegal_genome), 1);
    wr_cell(6, 0, 0, 0);
    wr_cell(9, 0, 3, 0);  check("R4 beyond level-back", int'(illegal_genome), 1);
    wr_cell(9, 0, 6, 0);  check("R4 at level-back", int'(illegal_genome), 0);
    wr_out(1, 14);        check("R4 out top net", int'(illegal_genome), 0);
    wr_out(1, 15);        check("R4 out beyond", int'(illegal_genome), 1);
    chk_y("R5 illegal out gives 0");
    wr_out(1, 7);

    for (int g = 0; g < 12; g++) begin
      for (int i = 0; i < NC; i++) wr_cell(i, int'($urandom % 16), pick(i / RW), pick(i / RW));
      for (int o = 0; o < NO; o++) wr_out(o, int'($urandom % NN));
      check("R4 random legal", int'(illegal_genome), 0);
      chk_y("R5 direct eval");
      check("R9 active", int'(active_cells), m_active());
      for (int c = 0; c < NCOMB; c++) wr_tgt(c, NO'($urandom));
      run_sweep(g == 3 || g == 7);
      for (int c = 0; c < NCOMB; c++) wr_tgt(c, m_eval(NI'(c)));
      check("R8 model says zero", m_score(), 0);
      run_sweep(1'b0);
    end

    for (int c = 0; c < NCOMB; c++) wr_tgt(c, ~m_eval(NI'(c)));
    run_sweep(1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule